// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port on APB

This block is a general-purpose I/O port of eight lines that sits on an APB slave interface. Each line can be an input or an output, and each line can be handed to a hardware source instead of software. The data register is reached through a window of 256 word addresses. Address bits [9:2] of each access act as a per-line mask. Software can therefore read or change any subset of lines in one access, without a read-modify-write sequence and with no race against other code that owns different lines.

Pin levels from outside pass through a two-flop synchronizer before a read can see them. For lines driven by the block, a data read returns the value that is being driven. Every access completes in the access phase with no wait states, and the error response is never raised.

Top module: `apb_gpio_masked`

## Requirements
- R1: After reset the software output value, direction and hardware-select state of every line are 0. All lines are then inputs under software control, so `gpio_oe` is 0x00 and `gpio_out` is 0x00.
- R2: A read anywhere in offsets 0x000–0x3FC returns, in `prdata[7:0]`, bit i equal to (`paddr[2+i]` AND pin value i), and returns 0 in `prdata[31:8]`. The pin value is `gpio_out[i]` when `gpio_oe[i]` is 1, and the synchronized `gpio_in[i]` otherwise.
- R3: A write anywhere in offsets 0x000–0x3FC loads `pwdata[i]` into software output bit i only where `paddr[2+i]` is 1. Every other output bit keeps its value.
- R4: The direction register is at offset 0x400, bits [7:0]. A 1 makes the line an output. For a line under software control, `gpio_oe[i]` equals direction bit i. The register reads back as written.
- R5: The hardware-select register is at offset 0x420, bits [7:0]. Where bit i is 1, `gpio_out[i]` follows `alt_out[i]` and `gpio_oe[i]` follows `alt_oe[i]`. Where bit i is 0, the software data and direction bits drive the line. The register reads back as written.
- R6: Offsets 0x404–0x41C and every other offset outside the data window, 0x400 and 0x420 read as 0. Writes to them change no state.
- R7: A change on `gpio_in` becomes visible to data reads after exactly two rising clock edges, and not after one.
- R8: `pready` is 1 and `pslverr` is 0 in every access phase, so each access takes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase flag |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset; bits [9:2] are the line mask in the data window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response, always 0 |
| gpio_in | input | 8 | Pin levels from outside |
| alt_out | input | 8 | Hardware-source drive values |
| alt_oe | input | 8 | Hardware-source output enables |
| gpio_out | output | 8 | Pin drive values |
| gpio_oe | output | 8 | Pin output enables |

## Verification
The assertions assume that the bus follows the APB order: a setup cycle with `psel` high and `penable` low, then one access cycle, with `paddr`, `pwrite` and `pwdata` held between the two. They also assume that `paddr` is word aligned. The bench drives every transfer through one pair of tasks that keep this order, and uses only offsets that are multiples of four. It changes `gpio_in` only between transfers, and waits for the synchronizer before it checks the new level.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_ALT  = 2'd3
  } reg_sel_e;

  localparam int unsigned MAP_AW      = 12;
  localparam logic [MAP_AW-1:0] OFS_DIR = 12'h400;
  localparam logic [MAP_AW-1:0] OFS_ALT = 12'h420;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NLINES = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] async_in,
  output logic [NLINES-1:0] sync_out
);

  logic [NLINES-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [NLINES-1:0] wr_mask,
  input  logic [NLINES-1:0] wr_val,
  output logic [NLINES-1:0] data_q,
  output logic [NLINES-1:0] dir_q,
  output logic [NLINES-1:0] alt_q
);

  logic [NLINES-1:0] data_d, dir_d, alt_d;
  logic              data_en, dir_en, alt_en;

  always_comb begin
    data_en = wr_en && (wr_sel == SEL_DATA);
    dir_en  = wr_en && (wr_sel == SEL_DIR);
    alt_en  = wr_en && (wr_sel == SEL_ALT);
    data_d  = (data_q & ~wr_mask) | (wr_val & wr_mask);
    dir_d   = wr_val;
    alt_d   = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= '0;
    end else if (alt_en) begin
      alt_q <= alt_d;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned NLINES = 8
) (
  input  logic [NLINES-1:0] alt_q,
  input  logic [NLINES-1:0] data_q,
  input  logic [NLINES-1:0] dir_q,
  input  logic [NLINES-1:0] alt_out,
  input  logic [NLINES-1:0] alt_oe,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe
);

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      assign pin_out[i] = alt_q[i] ? alt_out[i] : data_q[i];
      assign pin_oe[i]  = alt_q[i] ? alt_oe[i]  : dir_q[i];
    end
  endgenerate

endmodule

// File: rtl/apb_gpio_masked.sv
module apb_gpio_masked
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NLINES      = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NLINES-1:0] gpio_in,
  input  logic [NLINES-1:0] alt_out,
  input  logic [NLINES-1:0] alt_oe,
  output logic [NLINES-1:0] gpio_out,
  output logic [NLINES-1:0] gpio_oe
);

  localparam int unsigned MASK_LO  = 2;
  localparam int unsigned WIN_TOP  = MASK_LO + NLINES;
  localparam int unsigned WORD_MSB = ADDR_W - 1;

  reg_sel_e          sel;
  logic              wr_acc;
  logic [NLINES-1:0] addr_mask;
  logic [NLINES-1:0] data_q, dir_q, alt_q;
  logic [NLINES-1:0] pin_sync;
  logic [NLINES-1:0] pin_view;
  logic [NLINES-1:0] rd_bits;

  always_comb begin
    if (paddr[ADDR_W-1:WIN_TOP] == '0) begin
      sel = SEL_DATA;
    end else if (paddr[WORD_MSB:MASK_LO] == OFS_DIR[WORD_MSB:MASK_LO]) begin
      sel = SEL_DIR;
    end else if (paddr[WORD_MSB:MASK_LO] == OFS_ALT[WORD_MSB:MASK_LO]) begin
      sel = SEL_ALT;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign addr_mask = paddr[MASK_LO +: NLINES];
  assign wr_acc    = psel && penable && pwrite;

  gpio_in_sync #(
    .NLINES (NLINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (pclk),
    .rst_n    (presetn),
    .async_in (gpio_in),
    .sync_out (pin_sync)
  );

  gpio_regfile #(
    .NLINES (NLINES)
  ) u_regs (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_en   (wr_acc),
    .wr_sel  (sel),
    .wr_mask (addr_mask),
    .wr_val  (pwdata[NLINES-1:0]),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .alt_q   (alt_q)
  );

  gpio_pin_mux #(
    .NLINES (NLINES)
  ) u_mux (
    .alt_q   (alt_q),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pin_out (gpio_out),
    .pin_oe  (gpio_oe)
  );

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_view
      assign pin_view[i] = gpio_oe[i] ? gpio_out[i] : pin_sync[i];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_bits = pin_view & addr_mask;
      SEL_DIR:  rd_bits = dir_q;
      SEL_ALT:  rd_bits = alt_q;
      default:  rd_bits = '0;
    endcase
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      prdata[NLINES-1:0] = rd_bits;
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk #(
  parameter int unsigned NLINES = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [NLINES-1:0] data_q,
  input logic [NLINES-1:0] dir_q,
  input logic [NLINES-1:0] alt_q
);

  localparam int unsigned WIN_TOP = NLINES + 2;

  logic              in_win, is_dir, is_alt, acc_wr, acc_rd;
  logic [NLINES-1:0] msk;

  assign in_win = (paddr[ADDR_W-1:WIN_TOP] == '0);
  assign is_dir = (paddr == 12'h400);
  assign is_alt = (paddr == 12'h420);
  assign acc_wr = psel && penable && pwrite;
  assign acc_rd = psel && penable && !pwrite;
  assign msk    = paddr[2 +: NLINES];

  p_masked_bits_load_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && in_win) |=> ((data_q & $past(msk)) == ($past(pwdata[NLINES-1:0]) & $past(msk))));

  p_unmasked_bits_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && in_win) |=> (((data_q ^ $past(data_q)) & ~$past(msk)) == '0));

  p_read_mask_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_rd && in_win) |-> ((prdata[NLINES-1:0] & ~msk) == '0));

  p_upper_bits_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
    acc_rd |-> (prdata[DATA_W-1:NLINES] == '0));

  p_unmapped_write_ignored_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && !in_win && !is_dir && !is_alt) |=> ($stable(data_q) && $stable(dir_q) && $stable(alt_q)));

  p_unmapped_read_zero_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_rd && !in_win && !is_dir && !is_alt) |-> (prdata == '0));

endmodule

bind apb_gpio_masked gpio_mask_chk #(
  .NLINES (NLINES),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .data_q  (data_q),
  .dir_q   (dir_q),
  .alt_q   (alt_q)
);

// File: tb/apb_gpio_masked_tb.sv
module apb_gpio_masked_tb;

  localparam int CLK_PERIOD = 10;

  logic        pclk;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  gpio_in, alt_out, alt_oe, gpio_out, gpio_oe;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_data;

  apb_gpio_masked u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .gpio_in(gpio_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  initial pclk = 1'b0;
  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    check("R8 pready", {31'd0, pready}, 32'd1);
    check("R8 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    gpio_in = 8'h00; alt_out = 8'h00; alt_oe = 8'h00;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;

    // R1 reset state
    #1;
    check("R1 gpio_oe", {24'd0, gpio_oe}, 32'd0);
    check("R1 gpio_out", {24'd0, gpio_out}, 32'd0);
    bus_rd(12'h400, rd); check("R1 dir", rd, 32'd0);
    bus_rd(12'h420, rd); check("R1 alt", rd, 32'd0);
    bus_rd(12'h3FC, rd); check("R1 data", rd, 32'd0);

    // R4 direction
    bus_wr(12'h400, 32'hFFFF_FF5A);
    bus_rd(12'h400, rd); check("R4 dir readback", rd, 32'h5A);
    check("R4 gpio_oe", {24'd0, gpio_oe}, 32'h5A);
    bus_wr(12'h400, 32'h0000_00FF);
    check("R4 gpio_oe all", {24'd0, gpio_oe}, 32'hFF);

    // R3 masked write sweep over every mask
    exp_data = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] v;
      v = 8'((m * 37 + 11) & 255);
      bus_wr({2'b00, 8'(m), 2'b00}, {24'hABCDEF, v});
      exp_data = (exp_data & ~8'(m)) | (v & 8'(m));
      check("R3 masked write", {24'd0, gpio_out}, {24'd0, exp_data});
      if ((m % 16) == 5) begin
        bus_rd(12'h3FC, rd); check("R2 output readback", rd, {24'd0, exp_data});
      end
    end

    // R2 read mask sweep on inputs
    bus_wr(12'h400, 32'h00);
    gpio_in = 8'hA5;
    repeat (3) @(negedge pclk);
    for (int m = 0; m < 256; m++) begin
      bus_rd({2'b00, 8'(m), 2'b00}, rd);
      check("R2 masked read", rd, {24'd0, 8'hA5 & 8'(m)});
    end

    // R2 mixed direction
    bus_wr(12'h400, 32'h0F);
    for (int m = 0; m < 256; m += 17) begin
      bus_rd({2'b00, 8'(m), 2'b00}, rd);
      check("R2 mixed read", rd, {24'd0, ((exp_data & 8'h0F) | (8'hA5 & 8'hF0)) & 8'(m)});
    end

    // R7 synchronizer latency
    bus_wr(12'h400, 32'h00);
    @(negedge pclk);
    gpio_in = 8'h3C;
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'h3FC; penable = 1'b0;
    #1;
    check("R7 one edge old", prdata, 32'hA5);
    @(negedge pclk);
    #1;
    check("R7 two edges new", prdata, 32'h3C);
    @(negedge pclk);
    psel = 1'b0;

    // R5 hardware select
    bus_wr(12'h400, 32'h0F);
    alt_out = 8'h3C; alt_oe = 8'hAA;
    bus_wr(12'h420, 32'hF0);
    bus_rd(12'h420, rd); check("R5 alt readback", rd, 32'hF0);
    check("R5 gpio_oe", {24'd0, gpio_oe}, {24'd0, (8'hAA & 8'hF0) | 8'h0F});
    check("R5 gpio_out", {24'd0, gpio_out}, {24'd0, (8'h3C & 8'hF0) | (exp_data & 8'h0F)});
    alt_out = 8'hC3; alt_oe = 8'h55;
    #1;
    check("R5 follow hw", {24'd0, gpio_out}, {24'd0, (8'hC3 & 8'hF0) | (exp_data & 8'h0F)});
    check("R5 follow hw oe", {24'd0, gpio_oe}, {24'd0, (8'h55 & 8'hF0) | 8'h0F});
    bus_wr(12'h420, 32'h00);
    check("R5 back to sw", {24'd0, gpio_oe}, 32'h0F);

    // R6 unmapped offsets
    for (int a = 12'h404; a <= 12'h41C; a += 4) begin
      bus_wr(12'(a), 32'hFFFF_FFFF);
      bus_rd(12'(a), rd); check("R6 reserved read", rd, 32'd0);
    end
    bus_wr(12'h424, 32'hFF); bus_wr(12'h800, 32'hFF); bus_wr(12'hFFC, 32'hFF);
    bus_rd(12'h800, rd); check("R6 high read", rd, 32'd0);
    bus_rd(12'h400, rd); check("R6 dir kept", rd, 32'h0F);
    bus_rd(12'h420, rd); check("R6 alt kept", rd, 32'h00);
    check("R6 data kept", {24'd0, gpio_out}, {24'd0, exp_data});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule